// File: doc/BRIEF.md
# Prioritized Interrupt Request Arbiter

This block gathers a bank of interrupt request lines, 32 by default, and offers one winner at a time to a processor. Each line has its own 3-bit priority level, which software sets through a simple write port. A line whose level is 0 or 7 is switched off. A rising edge on a line sets a pending flag for that source. Among the pending sources that are switched on, the one with the highest level wins. When several winners share that level, the one with the lowest index wins.

The winner appears on a valid/ready output stream. `req_vec` carries the winner's index multiplied by four, which is a byte offset into a table of 32-bit entries. `req_lvl` carries the level that was programmed for it. Back-pressure follows the usual stream rule. Once `req_valid` is high, `req_vec` and `req_lvl` stay frozen until a cycle in which `req_ready` is also high. This holds even if a more urgent request arrives in the meantime.

A cycle with both `req_valid` and `req_ready` high is the vector read. It clears the pending flag of the presented source only. In the same clock edge the output register loads the next winner, if there is one, so requests can be handed out back to back.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset `req_valid` is low and every source's level is 0, so a request from a source that has never been programmed is not presented.
- R2: A rising edge on `irq_in[i]`, even one lasting a single cycle, is held as pending. The request appears on the outputs two clock edges after the edge is sampled and stays there until it is acknowledged.
- R3: A source whose level is 0 or 7 is never presented. `req_lvl` is never 0 or 7 while `req_valid` is high.
- R4: Among eligible pending sources, the one with the numerically highest level is presented.
- R5: When several eligible sources share the highest level, the one with the smallest index is presented.
- R6: `req_vec` equals the index of the presented source times 4, so its two low bits are zero. `req_lvl` equals that source's programmed level.
- R7: A handshake (`req_valid` and `req_ready` both high) clears only the presented source's pending flag. On the next cycle the outputs show the next winner, or `req_valid` goes low.
- R8: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_vec` and `req_lvl` hold their values, even if a higher-level request arrives.
- R9: Requests are edge-triggered. A line held high after its request is acknowledged does not raise a new request until it falls and rises again.
- R10: A pending flag captured while its source is disabled is kept. The request is presented once the source's level is changed to a value from 1 to 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | Request lines; a rising edge sets the pending flag |
| cfg_we | input | 1 | Level write strobe |
| cfg_idx | input | $clog2(NUM_SRC) | Source index for the level write |
| cfg_lvl | input | 3 | Level value written |
| req_valid | output | 1 | A winning request is presented |
| req_ready | input | 1 | Processor takes the vector this cycle |
| req_vec | output | $clog2(NUM_SRC)+2 | Winner index times 4 |
| req_lvl | output | 3 | Winner's programmed level |

## Verification
The assertions assume that `req_ready` is only taken as meaningful while `req_valid` is high. They also assume that request lines and level writes change only between clock edges, so every edge is sampled exactly once. The bench drives every input on the falling clock edge, raises `req_ready` for exactly one cycle per vector read, and programs levels before it pulses the matching lines. The one exception is the R10 case, where a level is written on purpose after the pending flag is already set.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] prio_t;

  localparam prio_t PRIO_OFF_LO = prio_t'(0);
  localparam prio_t PRIO_OFF_HI = prio_t'((1 << LVL_W) - 1);

  // A level of all zeros or all ones switches the source off.
  function automatic logic prio_live(prio_t l);
    return (l != PRIO_OFF_LO) && (l != PRIO_OFF_HI);
  endfunction
endpackage

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [NUM_SRC-1:0] clr_mask,
  output logic [NUM_SRC-1:0] pending
);
  logic [NUM_SRC-1:0] irq_q;
  logic [NUM_SRC-1:0] rise;

  assign rise = irq_in & ~irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= '0;
      pending <= '0;
    end else begin
      irq_q   <= irq_in;
      // a fresh edge wins over a clear in the same cycle
      pending <= (pending & ~clr_mask) | rise;
    end
  end
endmodule

// File: rtl/irq_level_regs.sv
module irq_level_regs
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  prio_t            cfg_lvl,
  output prio_t            lvl [NUM_SRC]
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lvl[i] <= PRIO_OFF_LO;
      else if (cfg_we && (cfg_idx == IDX_W'(i)))
        lvl[i] <= cfg_lvl;
    end
  end
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int LEAVES = 1 << IDX_W
) (
  input  logic [NUM_SRC-1:0] pending,
  input  logic [NUM_SRC-1:0] clr_mask,
  input  prio_t              lvl [NUM_SRC],
  output logic               win_ok,
  output logic [IDX_W-1:0]   win_idx,
  output prio_t              win_lvl
);
  typedef struct packed {
    logic             ok;
    prio_t            lvl;
    logic [IDX_W-1:0] idx;
  } node_t;

  // Left operand always carries the lower index, so ties keep it.
  function automatic node_t pick(node_t a, node_t b);
    if (b.ok && (!a.ok || (b.lvl > a.lvl)))
      return b;
    return a;
  endfunction

  node_t tree [1:2*LEAVES-1];

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < NUM_SRC) begin : g_real
      assign tree[LEAVES+j].ok  = pending[j] & ~clr_mask[j] & prio_live(lvl[j]);
      assign tree[LEAVES+j].lvl = lvl[j];
    end else begin : g_pad
      assign tree[LEAVES+j].ok  = 1'b0;
      assign tree[LEAVES+j].lvl = PRIO_OFF_LO;
    end
    assign tree[LEAVES+j].idx = IDX_W'(j);
  end

  for (genvar n = 1; n < LEAVES; n++) begin : g_node
    assign tree[n] = pick(tree[2*n], tree[2*n+1]);
  end

  assign win_ok  = tree[1].ok;
  assign win_idx = tree[1].idx;
  assign win_lvl = tree[1].lvl;
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int VEC_SHIFT = 2,
  localparam int IDX_W    = $clog2(NUM_SRC),
  localparam int VEC_W    = IDX_W + VEC_SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               win_ok,
  input  logic [IDX_W-1:0]   win_idx,
  input  prio_t              win_lvl,
  input  logic               req_ready,
  output logic               req_valid,
  output logic [VEC_W-1:0]   req_vec,
  output prio_t              req_lvl,
  output logic [NUM_SRC-1:0] clr_mask
);
  logic [IDX_W-1:0] idx_q;
  logic             fire;
  logic             load;

  assign fire = req_valid & req_ready;
  assign load = ~req_valid | req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      idx_q     <= '0;
      req_lvl   <= PRIO_OFF_LO;
    end else if (load) begin
      req_valid <= win_ok;
      idx_q     <= win_idx;
      req_lvl   <= win_lvl;
    end
  end

  assign req_vec = {idx_q, {VEC_SHIFT{1'b0}}};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
    assign clr_mask[i] = fire && (idx_q == IDX_W'(i));
  end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int VEC_SHIFT = 2,
  localparam int IDX_W    = $clog2(NUM_SRC),
  localparam int VEC_W    = IDX_W + VEC_SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [LVL_W-1:0]   cfg_lvl,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [VEC_W-1:0]   req_vec,
  output logic [LVL_W-1:0]   req_lvl
);
  logic [NUM_SRC-1:0] pending;
  logic [NUM_SRC-1:0] clr_mask;
  prio_t              lvl [NUM_SRC];
  logic               win_ok;
  logic [IDX_W-1:0]   win_idx;
  prio_t              win_lvl;

  irq_edge_capture #(.NUM_SRC(NUM_SRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .clr_mask(clr_mask), .pending(pending)
  );

  irq_level_regs #(.NUM_SRC(NUM_SRC)) u_lvl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_lvl(cfg_lvl), .lvl(lvl)
  );

  irq_prio_select #(.NUM_SRC(NUM_SRC)) u_sel (
    .pending(pending), .clr_mask(clr_mask), .lvl(lvl),
    .win_ok(win_ok), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  irq_out_stage #(.NUM_SRC(NUM_SRC), .VEC_SHIFT(VEC_SHIFT)) u_out (
    .clk(clk), .rst_n(rst_n), .win_ok(win_ok), .win_idx(win_idx),
    .win_lvl(win_lvl), .req_ready(req_ready), .req_valid(req_valid),
    .req_vec(req_vec), .req_lvl(req_lvl), .clr_mask(clr_mask)
  );
endmodule

// File: rtl/irq_prio_arbiter_chk.sv
module irq_prio_arbiter_chk #(
  parameter int VEC_W     = 7,
  parameter int VEC_SHIFT = 2,
  parameter int LVL_W     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VEC_W-1:0] req_vec,
  input logic [LVL_W-1:0] req_lvl
);
  assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_vec) && $stable(req_lvl)));

  assert_live_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_lvl != '0 && req_lvl != '1));

  assert_vec_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_vec[VEC_SHIFT-1:0] == '0));

  assert_ack_moves_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_valid || req_vec != $past(req_vec)));
endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(
  .VEC_W(VEC_W), .VEC_SHIFT(VEC_SHIFT), .LVL_W(irq_arb_pkg::LVL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
  .req_ready(req_ready), .req_vec(req_vec), .req_lvl(req_lvl)
);

// File: tb/irq_prio_arbiter_tb.sv
`timescale 1ns/1ps
module irq_prio_arbiter_tb;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_idx = '0;
  logic [2:0]  cfg_lvl = '0;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [6:0]  req_vec;
  logic [2:0]  req_lvl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_prio_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_lvl(cfg_lvl), .req_valid(req_valid),
    .req_ready(req_ready), .req_vec(req_vec), .req_lvl(req_lvl)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic set_lvl(input int idx, input int l);
    cfg_we = 1'b1; cfg_idx = 5'(idx); cfg_lvl = 3'(l);
    cyc(1);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    irq_in = irq_in | m;
    cyc(1);
    irq_in = irq_in & ~m;
  endtask

  task automatic ack();
    req_ready = 1'b1;
    cyc(1);
    req_ready = 1'b0;
  endtask

  task automatic expect_req(input string tag, input int vec, input int lvl);
    chk(req_valid === 1'b1, tag, int'(req_valid), 1);
    chk(req_vec == 7'(vec), tag, int'(req_vec), vec);
    chk(req_lvl == 3'(lvl), tag, int'(req_lvl), lvl);
  endtask

  task automatic expect_idle(input string tag);
    chk(req_valid === 1'b0, tag, int'(req_valid), 0);
  endtask

  task automatic t_reset();
    expect_idle("R1 reset valid");
    pulse(32'h1 << 3);
    cyc(3);
    expect_idle("R1 unprogrammed source stays hidden");
  endtask

  task automatic t_basic();
    set_lvl(5, 3);
    pulse(32'h1 << 5);
    cyc(1);
    expect_req("R2 R6 single pulse", 20, 3);
    cyc(5);
    expect_req("R2 held until ack", 20, 3);
    ack();
    expect_idle("R7 cleared after ack");
  endtask

  task automatic t_disabled();
    set_lvl(9, 7);
    pulse(32'h1 << 9);
    cyc(3);
    expect_idle("R3 level 7 blocked");
    set_lvl(9, 2);
    cyc(1);
    expect_req("R10 kept pending then enabled", 36, 2);
    ack();
    expect_idle("R7 idle after r10_ ack");
  endtask

  task automatic t_priority();
    set_lvl(1, 2); set_lvl(20, 6); set_lvl(30, 4);
    pulse((32'h1 << 1) | (32'h1 << 20) | (32'h1 << 30));
    cyc(1);
    expect_req("R4 highest level first", 80, 6);
    ack();
    expect_req("R4 R7 second winner", 120, 4);
    ack();
    expect_req("R7 third winner", 4, 2);
    ack();
    expect_idle("R7 all served");
  endtask

  task automatic t_tie();
    set_lvl(8, 5); set_lvl(2, 5); set_lvl(17, 5);
    pulse((32'h1 << 8) | (32'h1 << 2) | (32'h1 << 17));
    cyc(1);
    expect_req("R5 lowest index on tie", 8, 5);
    ack();
    expect_req("R5 next index", 32, 5);
    ack();
    expect_req("R5 last index", 68, 5);
    ack();
    expect_idle("R5 tie set served");
  endtask

  task automatic t_stall();
    set_lvl(10, 3); set_lvl(11, 6);
    pulse(32'h1 << 10);
    cyc(1);
    expect_req("R8 first presented", 40, 3);
    pulse(32'h1 << 11);
    cyc(3);
    expect_req("R8 held under stall", 40, 3);
    ack();
    expect_req("R8 urgent after ack", 44, 6);
    ack();
    expect_idle("R8 stall set served");
  endtask

  task automatic t_level_line();
    set_lvl(12, 4);
    irq_in[12] = 1'b1;
    cyc(2);
    expect_req("R9 line high request", 48, 4);
    ack();
    cyc(4);
    expect_idle("R9 steady high no repeat");
    irq_in[12] = 1'b0;
    cyc(2);
    pulse(32'h1 << 12);
    cyc(1);
    expect_req("R9 new edge re-requests", 48, 4);
    ack();
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_basic();
    t_disabled();
    t_priority();
    t_tie();
    t_stall();
    t_level_line();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule